// File: doc/BRIEF.md
# Per-Channel Thermal Shutdown Controller

This block protects a bank of output channels against overheating. Each channel has its own digitized junction temperature and its own on/off command. One digitized case temperature is shared by all channels. Each channel's gated drive follows its command while the channel is thermally healthy. A hot junction switches the channel off, and the channel turns itself back on once the junction has cooled past a lower threshold.

A second, outer loop watches the case. If the case overheats while a channel is already in thermal fault, that channel is held off until both the case and its own junction have cooled. Channels that are not in fault keep following their commands. A common active-low fault flag reports any channel in thermal fault, or a communication error. The flag is refreshed only when a status strobe fires, so between strobes it may be stale. The protection itself acts every cycle regardless of the strobe.

Every temperature is sampled into a register once per clock. Each channel runs a three-state machine:

- `CH_RUN`: healthy; the drive follows the command.
- `CH_JTRIP`: junction shutdown with automatic restart.
- `CH_CHOLD`: held off by the case loop.

The transitions are:

- `CH_RUN`→`CH_JTRIP` when the channel is commanded on and its sampled junction is above the junction shutdown threshold.
- `CH_JTRIP`→`CH_CHOLD` when the case-hot flag is set. This takes priority over restart.
- `CH_JTRIP`→`CH_RUN` when the junction is below the junction reset threshold.
- `CH_CHOLD`→`CH_RUN` when the case-hot flag is clear and the junction is below the junction reset threshold.

The case-hot flag has its own hysteresis. It sets when the sampled case temperature is above the case shutdown threshold and clears when it is below the case reset threshold.

Top module: `thermal_guard`

## Requirements
- R1: After reset every channel is in `CH_RUN`, `fault_n` is 1, and `drive_on` equals `cmd_on`.
- R2: A channel in `CH_RUN` drives `drive_on[i]` equal to `cmd_on[i]` in the same cycle, whatever the pattern of commands.
- R3: A commanded-on channel whose junction code is above `J_TRIP` is switched off two clock edges after the code is applied, and is still on after one edge.
- R4: A channel in junction shutdown stays off while its junction code is at or above `J_RESET`, and restarts by itself once the code is below `J_RESET` (the case-hot flag being clear).
- R5: If the case code goes above `C_TRIP` while a channel is in thermal fault, that channel stays off even after its junction has cooled. It restarts only once the case code is below `C_RESET` and its junction code is below `J_RESET`.
- R6: A case code above `C_TRIP` does not affect channels that are not in thermal fault; they keep following their commands.
- R7: A commanded-off channel never enters thermal fault, however hot its junction. A channel in fault that is commanded off leaves the fault as soon as its junction code is below `J_RESET`.
- R8: `fault_n` changes only on a clock edge where `stat_strobe` is 1. At that edge it takes the value 0 if any channel is in thermal fault or `comm_err` is 1, and 1 otherwise. It is not latched beyond the next strobe.
- R9: A junction code exactly equal to `J_TRIP` does not trip a channel. The comparison is strictly greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | N_CH | Per-channel on command, bit i for channel i |
| tj_code | input | N_CH*TW | Junction temperature codes, channel i at bits [i*TW +: TW], unsigned |
| tc_code | input | TW | Case temperature code, unsigned |
| comm_err | input | 1 | Communication error flag, active high |
| stat_strobe | input | 1 | Status update strobe; `fault_n` is refreshed at edges where it is 1 |
| drive_on | output | N_CH | Gated per-channel drive |
| fault_n | output | 1 | Common fault flag, active low |

## Verification
A channel machine stuck in or wrongly entering a fault state shows on `drive_on` for any commanded-on channel. A junction trip appears two edges after the temperature is applied. A case-driven hold or release appears one edge later still, because the case flag adds a register. A wrong internal state of a commanded-off channel is invisible on `drive_on`. It surfaces on `fault_n` only at the next status strobe, so the tests pulse the strobe after each thermal step and read the flag back.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,
        CH_JTRIP = 2'd1,
        CH_CHOLD = 2'd2
    } ch_state_e;
endpackage

// File: rtl/tg_case_monitor.sv
module tg_case_monitor #(
    parameter int TW      = 8,
    parameter int C_TRIP  = 130,
    parameter int C_RESET = 110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tc_s,
    output logic          case_hot
);
    localparam logic [TW-1:0] TRIP_C  = TW'(C_TRIP);
    localparam logic [TW-1:0] RESET_C = TW'(C_RESET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            case_hot <= 1'b0;
        else if (tc_s > TRIP_C)
            case_hot <= 1'b1;
        else if (tc_s < RESET_C)
            case_hot <= 1'b0;
    end
endmodule

// File: rtl/tg_channel_fsm.sv
module tg_channel_fsm
    import thermal_guard_pkg::*;
#(
    parameter int TW      = 8,
    parameter int J_TRIP  = 170,
    parameter int J_RESET = 150
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_on,
    input  logic [TW-1:0] tj_s,
    input  logic          case_hot,
    output logic          run,
    output logic          drive
);
    localparam logic [TW-1:0] TRIP_J  = TW'(J_TRIP);
    localparam logic [TW-1:0] RESET_J = TW'(J_RESET);

    ch_state_e state_q, state_d;
    logic      j_hot, j_cool;

    assign j_hot  = tj_s > TRIP_J;
    assign j_cool = tj_s < RESET_J;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_RUN:   if (cmd_on && j_hot)       state_d = CH_JTRIP;
            CH_JTRIP: if (case_hot)              state_d = CH_CHOLD;
                      else if (j_cool)           state_d = CH_RUN;
            CH_CHOLD: if (!case_hot && j_cool)   state_d = CH_RUN;
            default:                             state_d = CH_RUN;
        endcase
    end

    always_comb begin
        run   = 1'b0;
        drive = 1'b0;
        unique case (state_q)
            CH_RUN: begin
                run   = 1'b1;
                drive = cmd_on;
            end
            CH_JTRIP, CH_CHOLD: begin
                run   = 1'b0;
                drive = 1'b0;
            end
            default: begin
                run   = 1'b0;
                drive = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tg_fault_report.sv
module tg_fault_report #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stat_strobe,
    input  logic [N_CH-1:0] ch_run,
    input  logic            comm_err,
    output logic            fault_n
);
    logic any_fault;
    assign any_fault = (~ch_run != '0) || comm_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fault_n <= 1'b1;
        else if (stat_strobe)
            fault_n <= ~any_fault;
    end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
    parameter int N_CH    = 8,
    parameter int TW      = 8,
    parameter int J_TRIP  = 170,
    parameter int J_RESET = 150,
    parameter int C_TRIP  = 130,
    parameter int C_RESET = 110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    cmd_on,
    input  logic [N_CH*TW-1:0] tj_code,
    input  logic [TW-1:0]      tc_code,
    input  logic               comm_err,
    input  logic               stat_strobe,
    output logic [N_CH-1:0]    drive_on,
    output logic               fault_n
);
    logic [N_CH*TW-1:0] tj_s;
    logic [TW-1:0]      tc_s;
    logic               case_hot;
    logic [N_CH-1:0]    ch_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tj_s <= '0;
            tc_s <= '0;
        end else begin
            tj_s <= tj_code;
            tc_s <= tc_code;
        end
    end

    tg_case_monitor #(.TW(TW), .C_TRIP(C_TRIP), .C_RESET(C_RESET)) u_case (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_s     (tc_s),
        .case_hot (case_hot)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tg_channel_fsm #(.TW(TW), .J_TRIP(J_TRIP), .J_RESET(J_RESET)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_on   (cmd_on[i]),
            .tj_s     (tj_s[i*TW +: TW]),
            .case_hot (case_hot),
            .run      (ch_run[i]),
            .drive    (drive_on[i])
        );
    end

    tg_fault_report #(.N_CH(N_CH)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_strobe (stat_strobe),
        .ch_run      (ch_run),
        .comm_err    (comm_err),
        .fault_n     (fault_n)
    );
endmodule

// File: rtl/thermal_guard_checker.sv
module thermal_guard_checker #(
    parameter int N_CH    = 8,
    parameter int TW      = 8,
    parameter int J_TRIP  = 170,
    parameter int J_RESET = 150
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CH-1:0]    cmd_on,
    input logic [N_CH*TW-1:0] tj_s,
    input logic               case_hot,
    input logic [N_CH-1:0]    ch_run,
    input logic [N_CH-1:0]    drive_on,
    input logic               comm_err,
    input logic               stat_strobe,
    input logic               fault_n
);
    // R8: flag holds between strobes
    a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_strobe |=> $stable(fault_n));

    // R8: communication error reported at a strobe
    a_r8_comm_err_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_strobe && comm_err) |=> !fault_n);

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // R3: hot commanded-on channel leaves the running state
        a_r3_hot_trips: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_run[i] && cmd_on[i] && (tj_s[i*TW +: TW] > TW'(J_TRIP))) |=> !ch_run[i]);

        // R5: hot case keeps a faulted channel off
        a_r5_case_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[i] && case_hot) |=> !ch_run[i]);

        // R4: no restart while junction at or above reset threshold
        a_r4_no_early_restart: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[i] && (tj_s[i*TW +: TW] >= TW'(J_RESET))) |=> !ch_run[i]);

        // R2: a channel never drives against its command
        a_r2_drive_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
            drive_on[i] |-> cmd_on[i]);
    end
endmodule

bind thermal_guard thermal_guard_checker #(
    .N_CH(N_CH), .TW(TW), .J_TRIP(J_TRIP), .J_RESET(J_RESET)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_on      (cmd_on),
    .tj_s        (tj_s),
    .case_hot    (case_hot),
    .ch_run      (ch_run),
    .drive_on    (drive_on),
    .comm_err    (comm_err),
    .stat_strobe (stat_strobe),
    .fault_n     (fault_n)
);

// File: tb/thermal_guard_bench.sv
module thermal_guard_bench;
    localparam int N_CH = 8;
    localparam int TW   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_CH-1:0]    cmd_on = '0;
    logic [N_CH*TW-1:0] tj_code = '0;
    logic [TW-1:0]      tc_code = '0;
    logic               comm_err = 1'b0;
    logic               stat_strobe = 1'b0;
    logic [N_CH-1:0]    drive_on;
    logic               fault_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    thermal_guard u_thermal_guard (
        .clk (clk), .rst_n (rst_n), .cmd_on (cmd_on), .tj_code (tj_code),
        .tc_code (tc_code), .comm_err (comm_err), .stat_strobe (stat_strobe),
        .drive_on (drive_on), .fault_n (fault_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_tj(input int ch, input logic [7:0] v);
        tj_code[ch*TW +: TW] = v;
    endtask

    task automatic strobe();
        stat_strobe = 1'b1;
        tick(1);
        stat_strobe = 1'b0;
    endtask

    task automatic all_cool();
        for (int i = 0; i < N_CH; i++) set_tj(i, 8'd25);
        tc_code = 8'd25;
    endtask

    task automatic t_reset();
        chk("R1 fault_n after reset", {7'd0, fault_n}, 8'h01);
        chk("R1 drive after reset", drive_on, 8'h00);
    endtask

    task automatic t_follow();
        all_cool();
        cmd_on = 8'hFF; tick(3);
        chk("R2 all on", drive_on, 8'hFF);
        cmd_on = 8'hA5; #1;
        chk("R2 pattern A5", drive_on, 8'hA5);
        cmd_on = 8'h3C; #1;
        chk("R2 pattern 3C", drive_on, 8'h3C);
        cmd_on = 8'hFF; tick(1);
    endtask

    task automatic t_trip_hyst();
        set_tj(2, 8'd171);
        set_tj(5, 8'd170);
        tick(1);
        chk("R3 still on after one edge", drive_on, 8'hFF);
        tick(1);
        chk("R3 off after two edges", drive_on, 8'hFB);
        tick(3);
        chk("R9 equal to trip keeps running", drive_on, 8'hFB);
        set_tj(5, 8'd25);
        set_tj(2, 8'd160); tick(4);
        chk("R4 stays off inside hysteresis", drive_on, 8'hFB);
        set_tj(2, 8'd150); tick(4);
        chk("R4 stays off at reset code", drive_on, 8'hFB);
        set_tj(2, 8'd149); tick(3);
        chk("R4 auto restart", drive_on, 8'hFF);
    endtask

    task automatic t_case();
        tc_code = 8'd140; tick(4);
        chk("R6 hot case with no faults", drive_on, 8'hFF);
        tc_code = 8'd25; tick(4);
        set_tj(3, 8'd180); tick(4);
        chk("R3 channel 3 tripped", drive_on, 8'hF7);
        tc_code = 8'd131; tick(4);
        set_tj(3, 8'd100); tick(4);
        chk("R5 held with cool junction", drive_on, 8'hF7);
        chk("R6 others keep running", drive_on & 8'hF7, 8'hF7);
        tc_code = 8'd120; tick(4);
        chk("R5 held inside case hysteresis", drive_on, 8'hF7);
        tc_code = 8'd109; tick(4);
        chk("R5 released when both cool", drive_on, 8'hFF);
        tc_code = 8'd25; tick(2);
    endtask

    task automatic t_cmd_off();
        strobe(); tick(1);
        chk("R8 clear flag baseline", {7'd0, fault_n}, 8'h01);
        cmd_on = 8'hFD;
        set_tj(1, 8'd200); tick(4);
        strobe(); tick(1);
        chk("R7 commanded-off hot channel no fault", {7'd0, fault_n}, 8'h01);
        set_tj(1, 8'd25); tick(3);
        cmd_on = 8'hFF;
        set_tj(4, 8'd200); tick(4);
        cmd_on = 8'hEF; tick(3);
        strobe(); tick(1);
        chk("R7 off but still hot keeps fault", {7'd0, fault_n}, 8'h00);
        set_tj(4, 8'd140); tick(4);
        strobe(); tick(1);
        chk("R7 off and cool clears fault", {7'd0, fault_n}, 8'h01);
        cmd_on = 8'hFF; #1;
        chk("R7 drive back on at once", drive_on, 8'hFF);
    endtask

    task automatic t_report();
        set_tj(0, 8'd200); tick(4);
        chk("R8 no change without strobe", {7'd0, fault_n}, 8'h01);
        strobe(); tick(1);
        chk("R8 fault at strobe", {7'd0, fault_n}, 8'h00);
        set_tj(0, 8'd25); tick(4);
        chk("R8 stale until strobe", {7'd0, fault_n}, 8'h00);
        chk("R4 restarted while flag stale", drive_on, 8'hFF);
        strobe(); tick(1);
        chk("R8 not latched", {7'd0, fault_n}, 8'h01);
        comm_err = 1'b1; strobe(); tick(1);
        chk("R8 comm error", {7'd0, fault_n}, 8'h00);
        comm_err = 1'b0; strobe(); tick(1);
        chk("R8 comm error cleared", {7'd0, fault_n}, 8'h01);
    endtask

    initial begin
        all_cool();
        tick(2);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_follow();
        t_trip_hyst();
        t_case();
        t_cmd_off();
        t_report();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule